// File: doc/BRIEF.md
# Byte-Register Serial Slave with Broadcast Write

This block is a slave on a two-wire serial bus of the I2C/SMBus kind. It opens a 128-entry byte register space to a bus master through one internal 7-bit register pointer. A fast system clock oversamples SCL and SDA. Each line passes through a synchroniser and a stability filter. START, repeated START and STOP are then detected on the filtered lines. The slave pulls SDA low through an output-enable pin for its acknowledges and for read data. It never holds SCL low.

There are two ways to write. The first uses the slave's own 7-bit address. The second is a broadcast: the general-call byte, then a fixed identifier byte, then the pointer and the data. Both paths load and advance the same pointer. Reads are possible only through the slave's own address. The storage sits outside the block and is reached through a plain port: address, write data, a one-cycle write strobe, and read data that must follow the address within the same cycle. If either line stays low longer than a set number of clocks, the slave drops the transfer.

Top module: `busreg_slave`

## Requirements
- R1: In reset and right after it, `sda_oe` is 0, `reg_we` is 0 and the pointer on `reg_addr` is 0x00.
- R2: The slave acknowledges the address byte 0x40, which is address 0x20 with the read/write bit (bit 0) at 0 for a write. The first byte after it is loaded into the pointer. A STOP right after that byte writes nothing and leaves the pointer at the loaded value.
- R3: Each further write byte is stored at the pointer with one `reg_we` pulse. The pointer then goes up by one and wraps from 0x7F to 0x00.
- R4: An address byte of 0x41 starts a read at the current pointer. Each master acknowledge (SDA low on the ninth clock) moves the pointer up by one. A master non-acknowledge ends the read without moving the pointer and releases SDA. Data is sent MSB first.
- R5: The broadcast sequence is 0x00, then identifier 0x42, then the pointer byte, then data bytes. It is acknowledged and writes to consecutive registers exactly as an addressed write does.
- R6: If 0x00 is followed by any identifier other than 0x42, that byte gets no acknowledge. No later byte is acknowledged or written, and the pointer does not change, until the next START.
- R7: An address byte whose upper seven bits are not 0x20 gets no acknowledge. Nothing is written and the pointer does not change until the next START.
- R8: The byte 0x01 (general call with the read bit set) gets no acknowledge, so there is no broadcast read.
- R9: If SCL or SDA stays low longer than `TIMEOUT_CYC` clocks, the slave releases SDA and drops the transfer. A byte whose acknowledge had already begun stays written. Bytes clocked after the abort and before a new START get no acknowledge and are not written.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` clocks changes nothing: the byte carrying it is stored with its intended value and acknowledged.
- R11: For every byte the slave accepts, it starts pulling SDA low only while SCL is low, and holds it low through the whole ninth clock high period. A register write happens only while that acknowledge is driven.
- R12: A repeated START in the middle of a transfer restarts address decoding. A read that begins this way continues from the pointer the preceding write left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 7 | Register pointer, used as the storage address |
| reg_wdata | output | 8 | Byte to be stored |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Storage content at `reg_addr`, valid in the same cycle |

## Verification
The case that matters most is a timeout expiring while the slave is still driving an acknowledge. The stored byte and the pointer step have already happened, and the timeout wants to release SDA in the same cycle the acknowledge is still pending. The bench provokes this by stopping SCL low right after the eighth falling edge of a data byte and holding it past the timeout. It then checks three things: SDA is released, that byte remains written, and a byte clocked afterwards without a START is neither acknowledged nor stored. Read-back after a repeated START, plus a full comparison of the storage against a model kept from the requirements, closes each scenario.

// File: rtl/busreg_pkg.sv
package busreg_pkg;

    // Bus phase of the slave.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    // Meaning of the next received byte.
    typedef enum logic [1:0] {
        RO_ADDR,
        RO_GCID,
        RO_PTR,
        RO_DATA
    } role_e;

    // Line events seen on the filtered bus.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam logic [7:0] GC_BYTE = 8'h00;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/busreg_glitch_filt.sv
module busreg_glitch_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2, q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            q   <= 1'b1;
            cnt <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == q) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                q   <= s2;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign dout = q;
endmodule

// File: rtl/busreg_cond_det.sv
module busreg_cond_det
    import busreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    always_comb begin
        evt.start = scl & scl_p & sda_p & ~sda;
        evt.stop  = scl & scl_p & ~sda_p & sda;
        evt.rise  = scl & ~scl_p;
        evt.fall  = ~scl & scl_p;
    end
endmodule

// File: rtl/busreg_idle_tmo.sv
module busreg_idle_tmo #(
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic expire
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt;
    logic          low;

    assign low = ~(scl & sda);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= low && (cnt == TW'(TIMEOUT_CYC - 1));
            if (!low)
                cnt <= '0;
            else if (cnt != TW'(TIMEOUT_CYC))
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/busreg_slave.sv
module busreg_slave
    import busreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter logic [7:0] BCAST_ID    = 8'h42,
    parameter int         FILT_LEN    = 4,
    parameter int         TIMEOUT_CYC = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_w, filt_w;
    logic              scl_f, sda_f, expire;
    bus_evt_t          evt;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        busreg_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_w[g]),
            .dout (filt_w[g])
        );
    end

    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    busreg_cond_det u_det (
        .clk (clk),
        .rst (rst),
        .scl (scl_f),
        .sda (sda_f),
        .evt (evt)
    );

    busreg_idle_tmo #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .scl    (scl_f),
        .sda    (sda_f),
        .expire (expire)
    );

    phase_e     phase;
    role_e      role;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [6:0] ptr;
    logic       tx_next, mack_ok, we_q;
    logic [7:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            role    <= RO_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            tx_next <= 1'b0;
            mack_ok <= 1'b0;
            we_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            we_q <= 1'b0;
            if (we_q)
                ptr <= ptr + 1'b1;
            if (evt.start) begin
                phase   <= PH_RX;
                role    <= RO_ADDR;
                bitcnt  <= '0;
                tx_next <= 1'b0;
            end else if (evt.stop || expire) begin
                phase <= PH_IDLE;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (evt.rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (role)
                                RO_ADDR: begin
                                    if (addr_hit(shreg, DEV_ADDR)) begin
                                        phase   <= PH_ACK;
                                        tx_next <= shreg[0];
                                        role    <= RO_PTR;
                                    end else if (shreg == GC_BYTE) begin
                                        phase   <= PH_ACK;
                                        tx_next <= 1'b0;
                                        role    <= RO_GCID;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RO_GCID: begin
                                    if (shreg == BCAST_ID) begin
                                        phase <= PH_ACK;
                                        role  <= RO_PTR;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RO_PTR: begin
                                    phase <= PH_ACK;
                                    ptr   <= shreg[6:0];
                                    role  <= RO_DATA;
                                end
                                default: begin
                                    phase <= PH_ACK;
                                    we_q  <= 1'b1;
                                    wd_q  <= shreg;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (evt.fall) begin
                            if (tx_next) begin
                                phase  <= PH_TX;
                                shreg  <= reg_rdata;
                                bitcnt <= '0;
                            end else begin
                                phase <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (evt.fall) begin
                            if (bitcnt == 4'd7) begin
                                phase <= PH_MACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b1};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (evt.rise) begin
                            mack_ok <= ~sda_f;
                            if (!sda_f)
                                ptr <= ptr + 1'b1;
                        end else if (evt.fall) begin
                            if (mack_ok) begin
                                phase  <= PH_TX;
                                shreg  <= reg_rdata;
                                bitcnt <= '0;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = (phase == PH_ACK) || (phase == PH_TX && !shreg[7]);
    assign reg_addr  = ptr;
    assign reg_wdata = wd_q;
    assign reg_we    = we_q;
endmodule

// File: rtl/busreg_slave_chk.sv
module busreg_slave_chk #(
    parameter int TIMEOUT_CYC = 2_500_000,
    parameter int FILT_LEN    = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       scl_q,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [6:0] reg_addr
);
    localparam int unsigned LIM = TIMEOUT_CYC + 4 * FILT_LEN + 8;

    int unsigned lowcnt;

    always_ff @(posedge clk) begin
        if (rst || (scl_i && sda_i))
            lowcnt <= 0;
        else if (lowcnt < LIM)
            lowcnt <= lowcnt + 1;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!sda_oe && !reg_we));

    // R3
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_addr == $past(reg_addr) + 7'd1));

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R11
    ack_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_q);

    // R11
    ack_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> sda_oe);

    // R9
    tmo_release_chk: assert property (@(posedge clk) disable iff (rst)
        (lowcnt == LIM) |-> !sda_oe);
endmodule

bind busreg_slave busreg_slave_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .FILT_LEN    (FILT_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_f),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/busreg_slave_bench.sv
module busreg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 16;
    localparam int TMO        = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_we, sda_bus;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    logic [7:0] wbuf    [8];
    logic [6:0] exp_ptr;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    busreg_slave #(.TIMEOUT_CYC(TMO)) u_busreg_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] seed_val(input int i);
        return 8'(i * 37 + 11);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= seed_val(i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string msg, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; wt(HB);
        scl_m = 1'b1; wt(HB);
        sda_m = 1'b0; wt(HB);
        scl_m = 1'b0; wt(HB);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wt(HB);
        scl_m = 1'b1; wt(HB);
        sda_m = 1'b1; wt(HB);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wt(HB);
        scl_m = 1'b1; wt(HB);
        scl_m = 1'b0;
    endtask

    // bit with short pulses on both lines
    task automatic put_bit_g(input logic b);
        sda_m = b;    wt(HB/2);
        scl_m = 1'b1; wt(2);
        scl_m = 1'b0; wt(HB/2 - 2);
        scl_m = 1'b1; wt(HB/2);
        if (b) begin
            sda_m = 1'b0; wt(2);
            sda_m = 1'b1; wt(HB/2 - 2);
        end else begin
            wt(HB/2);
        end
        scl_m = 1'b0;
    endtask

    task automatic ack_slot(output bit ack);
        sda_m = 1'b1; wt(HB);
        scl_m = 1'b1; wt(HB/2);
        ack = ~sda_bus;
        wt(HB/2);
        scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) put_bit(b[k]);
        ack_slot(ack);
    endtask

    task automatic wbyte_g(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) put_bit_g(b[k]);
        ack_slot(ack);
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] d);
        for (int k = 7; k >= 0; k--) begin
            sda_m = 1'b1; wt(HB);
            scl_m = 1'b1; wt(HB/2);
            d[k] = sda_bus;
            wt(HB/2);
            scl_m = 1'b0;
        end
        sda_m = nack; wt(HB);
        scl_m = 1'b1; wt(HB);
        scl_m = 1'b0;
    endtask

    task automatic mem_all(input string msg);
        int bad = 0;
        for (int i = 0; i < 128; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, msg, bad, 0);
    endtask

    task automatic do_write(input bit bc, input logic [6:0] p, input int n, input bit fin);
        bit a;
        bstart();
        if (bc) begin
            wbyte(8'h00, a); chk(a, "R5 general-call byte ack", a, 1);
            wbyte(8'h42, a); chk(a, "R5 identifier ack", a, 1);
        end else begin
            wbyte(8'h40, a); chk(a, "R2 address ack", a, 1);
        end
        wbyte({1'b0, p}, a); chk(a, "R2 pointer byte ack", a, 1);
        exp_ptr = p;
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], a); chk(a, "R11 data byte ack", a, 1);
            exp_mem[exp_ptr] = wbuf[i];
            exp_ptr = exp_ptr + 7'd1;
        end
        if (fin) bstop();
    endtask

    task automatic do_read(input int n);
        bit         a;
        logic [7:0] d;
        bstart();
        wbyte(8'h41, a); chk(a, "R4 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i == n - 1, d);
            chk(d == exp_mem[exp_ptr], "R4 read data", d, exp_mem[exp_ptr]);
            if (i != n - 1) exp_ptr = exp_ptr + 7'd1;
        end
        bstop();
        chk(sda_oe == 1'b0, "R4 SDA free after nack", sda_oe, 0);
    endtask

    initial begin
        bit         a;
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) exp_mem[i] = seed_val(i);
        exp_ptr = '0;
        wt(6);
        chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        rst = 1'b0;
        wt(3);
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
        chk(reg_addr == 7'h00, "R1 pointer after reset", reg_addr, 0);

        // R2: pointer only, then STOP
        do_write(1'b0, 7'h10, 0, 1'b1);
        mem_all("R2 pointer-only write stores nothing");
        chk(reg_addr == 7'h10, "R2 pointer loaded", reg_addr, 7'h10);
        do_read(1);

        // R3 wrap, then R12 read after repeated START
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        do_write(1'b0, 7'h7E, 4, 1'b1);
        mem_all("R3 wrap write");
        chk(reg_addr == 7'h02, "R3 pointer after wrap", reg_addr, 7'h02);
        do_write(1'b0, 7'h7F, 0, 1'b0);
        do_read(3);

        // R5 broadcast
        wbuf[0] = 8'h5E; wbuf[1] = 8'h00; wbuf[2] = 8'hFF;
        do_write(1'b1, 7'h40, 3, 1'b1);
        mem_all("R5 broadcast write");

        // R6 wrong identifier
        bstart();
        wbyte(8'h00, a); chk(a, "R6 general-call byte ack", a, 1);
        wbyte(8'h43, a); chk(!a, "R6 wrong identifier nack", a, 0);
        wbyte(8'h10, a); chk(!a, "R6 later byte nack", a, 0);
        wbyte(8'h77, a); chk(!a, "R6 later byte nack", a, 0);
        bstop();
        mem_all("R6 nothing stored");
        chk(reg_addr == exp_ptr, "R6 pointer kept", reg_addr, exp_ptr);

        // R7 foreign address
        bstart();
        wbyte(8'h44, a); chk(!a, "R7 foreign address nack", a, 0);
        wbyte(8'h05, a); chk(!a, "R7 later byte nack", a, 0);
        wbyte(8'h99, a); chk(!a, "R7 later byte nack", a, 0);
        bstop();
        mem_all("R7 nothing stored");
        chk(reg_addr == exp_ptr, "R7 pointer kept", reg_addr, exp_ptr);

        // R8 broadcast read refused
        bstart();
        wbyte(8'h01, a); chk(!a, "R8 general-call read nack", a, 0);
        bstop();

        // R12 repeated START after a write
        wbuf[0] = 8'h3C; wbuf[1] = 8'hA9;
        do_write(1'b0, 7'h20, 2, 1'b0);
        do_read(2);

        // R9 stall during an acknowledge
        bstart();
        wbyte(8'h40, a);
        wbyte(8'h30, a);
        v = 8'hA5;
        for (int k = 7; k >= 0; k--) put_bit(v[k]);
        wt(HB);
        chk(sda_oe == 1'b1, "R11 ack driven while SCL low", sda_oe, 1);
        exp_mem[7'h30] = 8'hA5;
        exp_ptr = 7'h31;
        wt(TMO + 500);
        chk(sda_oe == 1'b0, "R9 SDA released after timeout", sda_oe, 0);
        wbyte(8'h5A, a); chk(!a, "R9 no ack after abort", a, 0);
        bstop();
        mem_all("R9 stored byte kept, later byte dropped");
        do_read(1);

        // R10 short pulses
        bstart();
        wbyte(8'h40, a);
        wbyte(8'h50, a);
        wbyte_g(8'hB7, a); chk(a, "R10 ack with pulses", a, 1);
        bstop();
        exp_mem[7'h50] = 8'hB7;
        exp_ptr = 7'h51;
        mem_all("R10 byte with pulses stored");

        // random mix
        for (int it = 0; it < 12; it++) begin
            bit         bc  = 1'($urandom % 2);
            bit         rep = 1'($urandom % 2);
            logic [6:0] p   = 7'($urandom % 128);
            int         n   = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(bc, p, n, 1'b1);
            do_write(1'b0, p, 0, !rep);
            do_read(n);
        end
        mem_all("R3 storage after random traffic");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule